// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Masked Interrupt

This block is an asynchronous serial port for a host that reaches it through plain read and write strobes on a 32-bit data path. It sends and receives 8-bit characters framed by one low start bit and one high stop bit, with no parity. The bit period is set by a programmable divisor that gives the number of system clocks per bit. Each direction has a single holding register. The host loads characters into the transmit holding register and reads them from the receive holding register.

Status flags describe the state of both directions:
- ready and empty state for transmit and receive,
- sticky error flags,
- a detected line break,
- the level of the clear-to-send input, and a latched change of that level,
- a match against a programmable end-of-packet character.

The control word has one enable bit per status flag, in the same positions. The single interrupt line is high whenever any enabled flag is set. Two control bits do not enable anything: one drives the request-to-send output and one forces the transmit line low to send a break. The host clears all sticky flags by writing to the status register, normally with the value zero.

Registers are decoded from byte address bits [4:2] within a 32-byte window:
- 0: received character
- 4: character to send
- 8: status
- 12: control
- 16: divisor
- 20: end-of-packet character

Reads are registered: `bus_rdata` is valid one clock after `bus_rd`.

Top module: `uart_mm`

## Requirements
- R1: After reset, the status register reads 0x060 (with `cts` low) and the control register reads 0. The divisor reads DIV_RESET. `txd` is high, and `rts` and `irq` are low.
- R2: A character written to offset 4 appears on `txd` as follows: one low start bit, then the eight data bits with the least significant bit first, then one high stop bit. Each bit lasts `divisor` clocks.
- R3: Status bit 6 (tx ready) is low while the transmit holding register is full. A write to offset 4 while it is full sets status bit 4 (tx overrun) and discards the character. A write in the same cycle that the shifter takes the held character is accepted.
- R4: Status bit 5 is high exactly when no character is being shifted out. While it is high, the holding register is empty and no break is forced, `txd` stays high.
- R5: The receiver samples `rxd` in the middle of each bit period. A complete frame puts the character in offset 0, bits [7:0], and sets status bit 7 (rx ready). Reading offset 0 clears bit 7.
- R6: A character that completes while bit 7 is still set sets status bit 3 (rx overrun) and replaces the held character.
- R7: A low stop bit sets status bit 1 (framing error). A frame that is low throughout, stop bit included, also sets status bit 2 (break).
- R8: Status bit 8 is the OR of bits 0 to 4. Bit 0 is always 0 because there is no parity. Any write to offset 8 clears bits 0–4, 8, 10 and 12, unless the same cycle sets a flag again.
- R9: `irq` is registered. It goes high one clock after status AND control is nonzero over the enable bits 0–8, 10 and 12.
- R10: Control bit 9 holds `txd` low, with one clock of latency. Control bit 11 drives `rts`.
- R11: Status bit 11 follows the synchronised `cts` level. Status bit 10 latches any change of that level until it is cleared by a status write.
- R12: Status bit 12 is set in two cases: when an accepted transmit character equals the end-of-packet register (offset 20, bits [7:0]), and when a read of a valid received character returns that value.
- R13: Offset 16 sets the divisor. A new value changes the bit period of both directions from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line |
| cts | input | 1 | Clear-to-send input, asynchronous |
| rts | output | 1 | Request-to-send output |

## Verification
The cycle that needs care is the one where a host write to the transmit data register lands on the same clock edge that the idle shifter takes the previously held character. The design must accept the new character there, not report an overrun. The bench provokes this with three back-to-back writes while the line is idle. The second write falls on the load edge and must be accepted. The third write finds the holding register full and must set the overrun flag. Judgement uses the status word and the decoded serial stream: the first two characters must appear in order, the third must never appear, and the tx overrun and exception bits must be set.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;
  localparam int STAT_W = 13;

  // word index = byte address [4:2]
  localparam logic [2:0] IDX_RXD  = 3'd0;
  localparam logic [2:0] IDX_TXD  = 3'd1;
  localparam logic [2:0] IDX_STAT = 3'd2;
  localparam logic [2:0] IDX_CTRL = 3'd3;
  localparam logic [2:0] IDX_DIV  = 3'd4;
  localparam logic [2:0] IDX_EOP  = 3'd5;

  // status bit positions (control enables share them)
  localparam int B_PE    = 0;
  localparam int B_FE    = 1;
  localparam int B_BRK   = 2;
  localparam int B_ROE   = 3;
  localparam int B_TOE   = 4;
  localparam int B_TMT   = 5;
  localparam int B_TRDY  = 6;
  localparam int B_RRDY  = 7;
  localparam int B_EXC   = 8;
  localparam int B_TXBRK = 9;
  localparam int B_DCTS  = 10;
  localparam int B_CTS   = 11;
  localparam int B_RTS   = 11;
  localparam int B_EOP   = 12;

  // control bits that act as interrupt enables
  localparam logic [STAT_W-1:0] IRQ_MASK = 13'h15FF;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/uart_mm_sync.sv
module uart_mm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic ff;
      always_ff @(posedge clk) begin
        if (rst) ff <= RESET_VAL;
        else     ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/uart_mm_tx.sv
module uart_mm_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             brk,
  input  logic             hold_valid,
  input  logic [7:0]       hold_data,
  output logic             load,
  output logic             busy,
  output logic             txd
);
  localparam int FRAME_BITS = 10;
  localparam int BC_W       = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [BC_W-1:0]       bits_left;
  logic [DIV_W-1:0]      cnt;
  logic                  line;

  // the shifter takes the held character whenever it is idle
  assign load = ~busy & hold_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      cnt       <= '0;
      line      <= 1'b1;
      txd       <= 1'b1;
    end else begin
      txd <= brk ? 1'b0 : line;
      if (load) begin
        shreg     <= {1'b1, hold_data, 1'b0};
        line      <= 1'b0;
        cnt       <= div - 1'b1;
        bits_left <= BC_W'(FRAME_BITS - 1);
        busy      <= 1'b1;
      end else if (busy) begin
        if (cnt == '0) begin
          if (bits_left == '0) begin
            busy <= 1'b0;
            line <= 1'b1;
          end else begin
            shreg     <= {1'b1, shreg[FRAME_BITS-1:1]};
            line      <= shreg[1];
            bits_left <= bits_left - 1'b1;
            cnt       <= div - 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_mm_rx.sv
module uart_mm_rx
  import uart_mm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             rx,
  output logic             done,
  output logic [7:0]       char_o,
  output logic             fe,
  output logic             brk
);
  rx_state_t        state;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       shreg;

  assign char_o = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      done  <= 1'b0;
      fe    <= 1'b0;
      brk   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!rx) begin
            cnt   <= div >> 1;
            state <= RX_START;
          end
        end
        RX_START: begin
          if (cnt == '0) begin
            if (!rx) begin
              cnt   <= div - 1'b1;
              bitn  <= '0;
              state <= RX_DATA;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == '0) begin
            shreg <= {rx, shreg[7:1]};
            cnt   <= div - 1'b1;
            if (bitn == 3'd7) state <= RX_STOP;
            else              bitn  <= bitn + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == '0) begin
            done  <= 1'b1;
            fe    <= ~rx;
            brk   <= ~rx & (shreg == 8'h00);
            state <= rx ? RX_IDLE : RX_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_HOLD: begin
          if (rx) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_mm.sv
module uart_mm
  import uart_mm_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DIV_RESET   = 434,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rxd,
  output logic        txd,
  input  logic        cts,
  output logic        rts
);
  logic [2:0]        idx;
  logic              wr_txd, wr_stat, wr_ctrl, wr_div, wr_eop, rd_rxd;
  logic              accept;
  logic [STAT_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_word;
  logic [DIV_W-1:0]  div_q;
  logic [7:0]        eop_q;
  logic [7:0]        hold_data;
  logic              hold_valid;
  logic [7:0]        rx_data_q;
  logic              rrdy_q, fe_q, brk_q, roe_q, toe_q, dcts_q, eop_hit_q;
  logic              cts_s, cts_prev, rx_s;
  logic              tx_load, tx_busy;
  logic              rx_done, rx_fe, rx_brk;
  logic [7:0]        rx_char;
  logic [31:0]       rd_mux;
  logic              unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  assign idx     = bus_addr[4:2];
  assign wr_txd  = bus_wr && (idx == IDX_TXD);
  assign wr_stat = bus_wr && (idx == IDX_STAT);
  assign wr_ctrl = bus_wr && (idx == IDX_CTRL);
  assign wr_div  = bus_wr && (idx == IDX_DIV);
  assign wr_eop  = bus_wr && (idx == IDX_EOP);
  assign rd_rxd  = bus_rd && (idx == IDX_RXD);
  assign accept  = wr_txd && (!hold_valid || tx_load);
  assign rts     = ctrl_q[B_RTS];

  uart_mm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
  );
  uart_mm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_cts_sync (
    .clk(clk), .rst(rst), .d(cts), .q(cts_s)
  );

  uart_mm_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .div(div_q), .brk(ctrl_q[B_TXBRK]),
    .hold_valid(hold_valid), .hold_data(hold_data),
    .load(tx_load), .busy(tx_busy), .txd(txd)
  );

  uart_mm_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .div(div_q), .rx(rx_s),
    .done(rx_done), .char_o(rx_char), .fe(rx_fe), .brk(rx_brk)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[B_PE]   = 1'b0;
    stat_word[B_FE]   = fe_q;
    stat_word[B_BRK]  = brk_q;
    stat_word[B_ROE]  = roe_q;
    stat_word[B_TOE]  = toe_q;
    stat_word[B_TMT]  = ~tx_busy;
    stat_word[B_TRDY] = ~hold_valid;
    stat_word[B_RRDY] = rrdy_q;
    stat_word[B_EXC]  = fe_q | brk_q | roe_q | toe_q;
    stat_word[B_DCTS] = dcts_q;
    stat_word[B_CTS]  = cts_s;
    stat_word[B_EOP]  = eop_hit_q;
  end

  always_comb begin
    case (idx)
      IDX_RXD:  rd_mux = {24'h0, rx_data_q};
      IDX_STAT: rd_mux = {{(32-STAT_W){1'b0}}, stat_word};
      IDX_CTRL: rd_mux = {{(32-STAT_W){1'b0}}, ctrl_q};
      IDX_DIV:  rd_mux = 32'(div_q);
      IDX_EOP:  rd_mux = {24'h0, eop_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      div_q      <= DIV_W'(DIV_RESET);
      eop_q      <= '0;
      hold_data  <= '0;
      hold_valid <= 1'b0;
      rx_data_q  <= '0;
      rrdy_q     <= 1'b0;
      fe_q       <= 1'b0;
      brk_q      <= 1'b0;
      roe_q      <= 1'b0;
      toe_q      <= 1'b0;
      dcts_q     <= 1'b0;
      eop_hit_q  <= 1'b0;
      cts_prev   <= 1'b0;
      irq        <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[STAT_W-1:0];
      if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_eop)  eop_q  <= bus_wdata[7:0];

      if (accept) begin
        hold_data  <= bus_wdata[7:0];
        hold_valid <= 1'b1;
      end else if (tx_load) begin
        hold_valid <= 1'b0;
      end

      if (rx_done) rx_data_q <= rx_char;
      rrdy_q <= rx_done | (rrdy_q & ~rd_rxd);

      // new events win over a clearing status write in the same cycle
      fe_q   <= (rx_done & rx_fe)            | (fe_q  & ~wr_stat);
      brk_q  <= (rx_done & rx_brk)           | (brk_q & ~wr_stat);
      roe_q  <= (rx_done & rrdy_q & ~rd_rxd) | (roe_q & ~wr_stat);
      toe_q  <= (wr_txd & ~accept)           | (toe_q & ~wr_stat);
      dcts_q <= (cts_s ^ cts_prev)           | (dcts_q & ~wr_stat);
      cts_prev <= cts_s;
      eop_hit_q <= (accept && (bus_wdata[7:0] == eop_q))
                 | (rd_rxd && rrdy_q && (rx_data_q == eop_q))
                 | (eop_hit_q & ~wr_stat);

      irq <= |(stat_word & ctrl_q & IRQ_MASK);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/uart_mm_checker.sv
module uart_mm_checker
  import uart_mm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [4:0]        bus_addr,
  input logic [STAT_W-1:0] stat_word,
  input logic [STAT_W-1:0] ctrl_word,
  input logic              irq,
  input logic              txd,
  input logic              rx_done,
  input logic              tx_load
);
  logic [2:0] idx;
  assign idx = bus_addr[4:2];

  AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == IDX_TXD && !stat_word[B_TRDY] && !tx_load) |=> stat_word[B_TOE]); // R3

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (stat_word[B_TMT] && stat_word[B_TRDY] && !ctrl_word[B_TXBRK]) |=> txd); // R4

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx == IDX_RXD && !rx_done) |=> !stat_word[B_RRDY]); // R5

  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (rx_done && stat_word[B_RRDY] && !(bus_rd && idx == IDX_RXD)) |=> stat_word[B_ROE]); // R6

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == IDX_STAT && !rx_done) |=> (stat_word[4:0] == 5'b0 && !stat_word[B_EXC])); // R8

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(stat_word & ctrl_word & IRQ_MASK)) |=> irq); // R9

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_word & ctrl_word & IRQ_MASK)) |=> !irq); // R9

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[B_TXBRK] |=> !txd); // R10
endmodule

bind uart_mm uart_mm_checker u_uart_mm_checker (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .stat_word(stat_word), .ctrl_word(ctrl_q), .irq(irq), .txd(txd),
  .rx_done(rx_done), .tx_load(tx_load)
);

// File: tb/uart_mm_bench.sv
module uart_mm_bench;
  localparam logic [4:0] A_RXD  = 5'd0;
  localparam logic [4:0] A_TXD  = 5'd4;
  localparam logic [4:0] A_STAT = 5'd8;
  localparam logic [4:0] A_CTRL = 5'd12;
  localparam logic [4:0] A_DIV  = 5'd16;
  localparam logic [4:0] A_EOP  = 5'd20;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, rxd, txd, cts, rts;

  int vectors = 0;
  int miscompares = 0;
  int div_cur = 434;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_mm u_uart_mm (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rxd(rxd), .txd(txd), .cts(cts), .rts(rts)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capture_tx(input string req, input logic [7:0] exp);
    logic [7:0] got;
    logic st, sp;
    int guard = 0;
    while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    repeat (div_cur / 2) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (div_cur) @(negedge clk);
      got[i] = txd;
    end
    repeat (div_cur) @(negedge clk);
    sp = txd;
    check(req, {22'h0, st, sp, got}, {22'h0, 1'b0, 1'b1, exp});
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop_v);
    rxd = 1'b0;
    repeat (div_cur) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (div_cur) @(negedge clk);
    end
    rxd = stop_v;
    repeat (div_cur) @(negedge clk);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(A_STAT, d); check("R1 status", d, 32'h060);
    bus_read(A_CTRL, d); check("R1 control", d, 32'h0);
    bus_read(A_DIV, d);  check("R1 divisor", d, 32'd434);
    check("R1 lines", {29'h0, txd, rts, irq}, {29'h0, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    bus_write(A_DIV, 32'd8); div_cur = 8;
    bus_write(A_TXD, 32'hA5);
    idle(1);
    bus_read(A_STAT, d); check("R4 shifting, holder free", d, 32'h040);
    capture_tx("R2 frame A5", 8'hA5);
    idle(2 * div_cur);
    bus_read(A_STAT, d); check("R4 idle again", d, 32'h060);
  endtask

  task automatic t_tx_collide;
    logic [31:0] d;
    bus_write(A_TXD, 32'h3C);
    bus_write(A_TXD, 32'hC3);   // lands on the load edge: accepted
    bus_write(A_TXD, 32'h7E);   // holder full: dropped
    bus_read(A_STAT, d); check("R3 holder full, overrun set", d, 32'h110);
    capture_tx("R3 first char", 8'h3C);
    capture_tx("R3 second char accepted", 8'hC3);
    idle(3 * div_cur);
    bus_read(A_STAT, d); check("R3 dropped char never sent, line idle", {d[31:1], txd}, 32'h171);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); check("R8 status write clears", d, 32'h060);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    send_rx(8'h96, 1'b1);
    bus_read(A_STAT, d); check("R5 rx ready", d, 32'h0E0);
    bus_read(A_RXD, d);  check("R5 rx data", d, 32'h96);
    bus_read(A_STAT, d); check("R5 read clears ready", d, 32'h060);
  endtask

  task automatic t_rx_overrun;
    logic [31:0] d;
    send_rx(8'h11, 1'b1);
    send_rx(8'h22, 1'b1);
    bus_read(A_STAT, d); check("R6 overrun flags", d, 32'h1E8);
    bus_read(A_RXD, d);  check("R6 newest char kept", d, 32'h22);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); check("R8 clear after overrun", d, 32'h060);
  endtask

  task automatic t_rx_errors;
    logic [31:0] d;
    send_rx(8'h55, 1'b0);
    bus_read(A_STAT, d); check("R7 framing error", d, 32'h1E2);
    bus_read(A_RXD, d);  check("R7 framed char", d, 32'h55);
    bus_write(A_STAT, 32'h0);
    send_rx(8'h00, 1'b0);
    bus_read(A_STAT, d); check("R7 break plus framing", d, 32'h1E6);
    bus_read(A_RXD, d);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); check("R8 clear after break", d, 32'h060);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    bus_write(A_CTRL, 32'h080);
    idle(2); check("R9 masked source idle", {31'h0, irq}, 32'h0);
    send_rx(8'h5A, 1'b1);
    idle(1); check("R9 rx ready raises irq", {31'h0, irq}, 32'h1);
    bus_read(A_RXD, d);
    idle(2); check("R9 irq drops after read", {31'h0, irq}, 32'h0);
    bus_write(A_CTRL, 32'h040);
    idle(1); check("R9 tx ready raises irq", {31'h0, irq}, 32'h1);
    bus_write(A_CTRL, 32'h0);
    idle(1); check("R9 all disabled", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_ctrl_lines;
    bus_write(A_CTRL, 32'h800);
    check("R10 rts follows control", {31'h0, rts}, 32'h1);
    bus_write(A_CTRL, 32'h200);
    idle(2);
    check("R10 break holds txd low, rts off", {30'h0, txd, rts}, 32'h0);
    bus_write(A_CTRL, 32'h0);
    idle(2);
    check("R10 txd released", {31'h0, txd}, 32'h1);
  endtask

  task automatic t_cts;
    logic [31:0] d;
    cts = 1'b1; idle(5);
    bus_read(A_STAT, d); check("R11 cts high and changed", d, 32'hC60);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); check("R11 change cleared, level kept", d, 32'h860);
    cts = 1'b0; idle(5);
    bus_read(A_STAT, d); check("R11 falling change", d, 32'h460);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); check("R11 clean", d, 32'h060);
  endtask

  task automatic t_eop;
    logic [31:0] d;
    bus_write(A_EOP, 32'h0D);
    bus_read(A_EOP, d);  check("R12 eop readback", d, 32'h0D);
    bus_write(A_TXD, 32'h0D);
    idle(1);
    bus_read(A_STAT, d); check("R12 eop on transmit", d, 32'h1040);
    capture_tx("R12 eop char sent", 8'h0D);
    idle(2 * div_cur);
    bus_write(A_STAT, 32'h0);
    send_rx(8'h0D, 1'b1);
    bus_read(A_STAT, d); check("R12 no match before read", d, 32'h0E0);
    bus_read(A_RXD, d);
    bus_read(A_STAT, d); check("R12 eop on receive read", d, 32'h1060);
    bus_write(A_STAT, 32'h0);
  endtask

  task automatic t_div;
    logic [31:0] d;
    bus_write(A_DIV, 32'd12); div_cur = 12;
    bus_read(A_DIV, d); check("R13 divisor readback", d, 32'd12);
    bus_write(A_TXD, 32'h69);
    capture_tx("R13 tx at new rate", 8'h69);
    idle(2 * div_cur);
    send_rx(8'hB4, 1'b1);
    bus_read(A_RXD, d); check("R13 rx at new rate", d, 32'hB4);
  endtask

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    rxd = 1'b1; cts = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_collide();
    t_rx_basic();
    t_rx_overrun();
    t_rx_errors();
    t_irq();
    t_ctrl_lines();
    t_cts();
    t_eop();
    t_div();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule